// File: doc/BRIEF.md
# Serial Command Token Framer

This block sits on the host side of a single bidirectional serial command line. For each request it accepts a 6-bit command index and a 32-bit argument and builds a 48-bit token. The token carries a start bit, a host-direction bit, the index, the argument, a 7-bit CRC and an end bit. The block shifts the token out most significant bit first, one bit per serial clock enable, and drives a separate output-enable for the line's tri-state buffer.

With each request the host also says what kind of reply to expect: none, a short 48-bit token or a long 136-bit token. When a reply is expected, the block releases the line after the command and watches for a start bit. It captures the token, then reports it in one pulse together with its flags:

- a framing error when the end bit is 0;
- a CRC error when a short reply's CRC does not match;
- a timeout when no start bit arrives in time.

The request interface is valid/ready. A new command is accepted only once the previous exchange has completed.

Top module: `cmd_line_framer`

## Requirements
- R1: After synchronous reset `line_oe` is 0, `line_out` is 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted request makes the block drive exactly 48 bits, one per `bit_en` pulse, with `line_oe` high for all of them. The bits go out MSB first in this order: 0, 1, `req_index[5:0]`, `req_arg[31:0]`, CRC[6:0], 1. On the 49th `bit_en` pulse, `line_oe` returns to 0 and `line_out` returns to 1.
- R3: The CRC is computed with polynomial x^7+x^3+1 from a zero seed over the first 40 token bits. For index 0 with argument 0 it is 7'h4A; for index 8 with argument 32'h1AA it is 7'h43.
- R4: `req_ready` is 1 only when no exchange is in progress. A request held valid while `req_ready` is 0 is not taken: the line stays released after the exchange once `req_valid` has dropped.
- R5: With `req_rsp` = 2'b00, no `rsp_valid` is produced, and `req_ready` is 1 right after the 49th pulse.
- R6: With `req_rsp` = 2'b01, listening starts on the 50th pulse. The first 0 sampled on `line_in` begins a 48-bit capture. `rsp_valid` pulses for one clock on the pulse that samples the last bit. At that point `rsp_bits[47:0]` holds the token, the first bit received sits in bit 47, the upper bits are 0 and `rsp_long` is 0.
- R7: With `req_rsp` = 2'b10 or 2'b11, the capture is 136 bits long into `rsp_bits[135:0]`, and `rsp_long` is 1.
- R8: `rsp_crc_err` is 1 on a short reply when the CRC over the reply's first 40 bits differs from its bits [7:1]. It is always 0 on a long reply.
- R9: `rsp_frame_err` is 1 exactly when the last bit of the reply is 0.
- R10: If 64 listening pulses all sample 1, `rsp_valid` pulses on the 64th with `rsp_timeout` = 1, the other flags 0 and `rsp_bits` = 0. A start bit on the 64th listening pulse is still accepted.
- R11: Without a `bit_en` pulse, `line_out` and `line_oe` do not change and no line bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One pulse per serial bit time |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Block can accept a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp | input | 2 | Expected reply: 00 none, 01 short, 1x long |
| line_in | input | 1 | Sampled level of the command line |
| line_out | output | 1 | Level driven onto the command line |
| line_oe | output | 1 | Output enable for the line driver |
| rsp_valid | output | 1 | One-clock pulse: reply or timeout reported |
| rsp_bits | output | 136 | Captured reply, right-aligned |
| rsp_long | output | 1 | Reported reply was a long one |
| rsp_timeout | output | 1 | No start bit within the listening window |
| rsp_crc_err | output | 1 | Short reply CRC mismatch |
| rsp_frame_err | output | 1 | Reply end bit was 0 |

## Verification
The bench sweeps all 64 command indices and rotates through the three reply kinds. For each one it computes the expected token and the expected CRC arithmetically, so a wrong polynomial, bit order or framing bit shows up as a token mismatch. Short and long replies are sent after start delays from 0 to 63 listening pulses, some with a corrupted CRC or a bad end bit. A design that mis-sizes its counters therefore reports one bit early or late, and a design that checks the CRC on long replies raises false errors. Two further cases probe the edges of the listening window: a start bit on the 64th listening pulse, which must be accepted, and a line held high for all 64 pulses, which must time out. A design with an off-by-one window either times out a valid reply or waits one pulse too long. The bench also holds a request valid during a busy exchange to catch a design that accepts it.

// File: rtl/cmdf_pkg.sv
// Shared constants and the CRC step for the command line framer.
// Assumes a 7-bit CRC fed one bit at a time, most significant bit first.
package cmdf_pkg;
    localparam int CRC_W = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    // Advance the CRC register by one data bit
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/cmdf_tx.sv
// Transmit shifter: loads a header, then on each bit enable drives one token
// bit (header, running CRC, end bit). On the enable after the last bit it
// releases the line and raises a one-cycle finish indication (combinational).
// Assumes load is only asserted while the shifter is idle.
module cmdf_tx
    import cmdf_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             busy,
    output logic             finish,
    output logic             line_out,
    output logic             line_oe
);
    localparam int HDR_W = 2 + IDX_W + ARG_W;
    localparam int TOK_W = HDR_W + CRC_W + 1;
    localparam int CNT_W = $clog2(TOK_W + 1);
    localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] CNT_CRC = CNT_W'(HDR_W + CRC_W);
    localparam logic [CNT_W-1:0] CNT_TOK = CNT_W'(TOK_W);

    logic [HDR_W-1:0] hdr_q;
    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Finish happens on the enable after the last token bit
    assign finish = busy_q && bit_en && (cnt_q == CNT_TOK);
    assign busy   = busy_q;

    // Load, shift out and release the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            crc_q    <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
            line_out <= 1'b1;
            line_oe  <= 1'b0;
        end else if (load && !busy_q) begin
            hdr_q  <= {1'b0, 1'b1, idx, arg};
            crc_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && bit_en) begin
            if (cnt_q == CNT_TOK) begin
                busy_q   <= 1'b0;
                line_oe  <= 1'b0;
                line_out <= 1'b1;
            end else begin
                line_oe <= 1'b1;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q < CNT_HDR) begin
                    line_out <= hdr_q[HDR_W-1];
                    hdr_q    <= {hdr_q[HDR_W-2:0], 1'b0};
                    crc_q    <= crc_step(crc_q, hdr_q[HDR_W-1]);
                end else if (cnt_q < CNT_CRC) begin
                    line_out <= crc_q[CRC_W-1];
                    crc_q    <= {crc_q[CRC_W-2:0], 1'b0};
                end else begin
                    line_out <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmdf_rx.sv
// Reply receiver: after start, samples the line on each bit enable, waits up
// to TIMEOUT_TICKS enables for a 0 start bit, then captures a short or long
// token and reports it with framing, CRC and timeout flags in one pulse.
// Assumes the line idles high while released.
module cmdf_rx
    import cmdf_pkg::*;
#(
    parameter int SHORT_BITS    = 48,
    parameter int LONG_BITS     = 136,
    parameter int CRC_SPAN      = 40,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 start,
    input  logic                 long_sel,
    input  logic                 line_in,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [LONG_BITS-1:0] rsp_bits,
    output logic                 rsp_long,
    output logic                 rsp_timeout,
    output logic                 rsp_crc_err,
    output logic                 rsp_frame_err
);
    localparam int BC_W = $clog2(LONG_BITS + 1);
    localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [BC_W-1:0] LAST_SHORT = BC_W'(SHORT_BITS - 1);
    localparam logic [BC_W-1:0] LAST_LONG  = BC_W'(LONG_BITS - 1);
    localparam logic [BC_W-1:0] BC_SPAN    = BC_W'(CRC_SPAN);
    localparam logic [TO_W-1:0] TO_LAST    = TO_W'(TIMEOUT_TICKS - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_CAPT} rx_state_e;

    rx_state_e      st_q;
    logic [TO_W-1:0] wait_q;
    logic [BC_W-1:0] bit_q;
    logic [CRC_W-1:0] crc_q;
    logic            long_q;
    logic [BC_W-1:0] last_bit;

    assign last_bit = long_q ? LAST_LONG : LAST_SHORT;
    assign busy     = (st_q != RX_IDLE);
    assign rsp_long = long_q;

    // Wait for the start bit, capture the token and report it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= RX_IDLE;
            wait_q        <= '0;
            bit_q         <= '0;
            crc_q         <= '0;
            long_q        <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_bits      <= '0;
            rsp_timeout   <= 1'b0;
            rsp_crc_err   <= 1'b0;
            rsp_frame_err <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (st_q)
                RX_IDLE: if (start) begin
                    st_q   <= RX_WAIT;
                    wait_q <= '0;
                    long_q <= long_sel;
                end
                RX_WAIT: if (bit_en) begin
                    if (!line_in) begin
                        st_q          <= RX_CAPT;
                        rsp_bits      <= '0;
                        bit_q         <= BC_W'(1);
                        crc_q         <= crc_step('0, 1'b0);
                        rsp_timeout   <= 1'b0;
                        rsp_crc_err   <= 1'b0;
                        rsp_frame_err <= 1'b0;
                    end else if (wait_q == TO_LAST) begin
                        st_q          <= RX_IDLE;
                        rsp_valid     <= 1'b1;
                        rsp_bits      <= '0;
                        rsp_timeout   <= 1'b1;
                        rsp_crc_err   <= 1'b0;
                        rsp_frame_err <= 1'b0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                RX_CAPT: if (bit_en) begin
                    rsp_bits <= {rsp_bits[LONG_BITS-2:0], line_in};
                    bit_q    <= bit_q + 1'b1;
                    if (bit_q < BC_SPAN) begin
                        crc_q <= crc_step(crc_q, line_in);
                    end
                    if (bit_q == last_bit) begin
                        st_q          <= RX_IDLE;
                        rsp_valid     <= 1'b1;
                        rsp_frame_err <= !line_in;
                        rsp_crc_err   <= !long_q && (crc_q != rsp_bits[CRC_W-1:0]);
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_line_framer.sv
// Top of the command line framer: accepts a request, sends the command token
// through the transmit shifter, then hands the line to the receiver when a
// reply is expected. Assumes bit_en is a single-clock pulse per bit time.
module cmd_line_framer
    import cmdf_pkg::*;
#(
    parameter int IDX_W         = 6,
    parameter int ARG_W         = 32,
    parameter int SHORT_BITS    = 48,
    parameter int LONG_BITS     = 136,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [IDX_W-1:0]     req_index,
    input  logic [ARG_W-1:0]     req_arg,
    input  logic [1:0]           req_rsp,
    input  logic                 line_in,
    output logic                 line_out,
    output logic                 line_oe,
    output logic                 rsp_valid,
    output logic [LONG_BITS-1:0] rsp_bits,
    output logic                 rsp_long,
    output logic                 rsp_timeout,
    output logic                 rsp_crc_err,
    output logic                 rsp_frame_err
);
    localparam int CRC_SPAN = 2 + IDX_W + ARG_W;

    logic       accept;
    logic       tx_busy;
    logic       tx_finish;
    logic       rx_busy;
    logic       rx_start;
    logic [1:0] kind_q;

    assign req_ready = !tx_busy && !rx_busy;
    assign accept    = req_valid && req_ready;
    assign rx_start  = tx_finish && (kind_q != 2'b00);

    // Remember the expected reply kind for the accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= 2'b00;
        end else if (accept) begin
            kind_q <= req_rsp;
        end
    end

    cmdf_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .load     (accept),
        .idx      (req_index),
        .arg      (req_arg),
        .busy     (tx_busy),
        .finish   (tx_finish),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    cmdf_rx #(
        .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS),
        .CRC_SPAN(CRC_SPAN), .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en        (bit_en),
        .start         (rx_start),
        .long_sel      (kind_q[1]),
        .line_in       (line_in),
        .busy          (rx_busy),
        .rsp_valid     (rsp_valid),
        .rsp_bits      (rsp_bits),
        .rsp_long      (rsp_long),
        .rsp_timeout   (rsp_timeout),
        .rsp_crc_err   (rsp_crc_err),
        .rsp_frame_err (rsp_frame_err)
    );
endmodule

// File: rtl/cmdf_checker.sv
// Property checker for the command line framer, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module cmdf_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic req_valid,
    input logic req_ready,
    input logic line_out,
    input logic line_oe,
    input logic rsp_valid,
    input logic rsp_long,
    input logic rsp_timeout,
    input logic rsp_crc_err,
    input logic rsp_frame_err
);
    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_out) && $stable(line_oe)); // R11
    AST_BUSY_WHILE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> !req_ready); // R4
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
    AST_LONG_NO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_long |-> !rsp_crc_err); // R8
    AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_timeout |-> !rsp_crc_err && !rsp_frame_err); // R10
    AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_out); // R2
endmodule

bind cmd_line_framer cmdf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .line_out      (line_out),
    .line_oe       (line_oe),
    .rsp_valid     (rsp_valid),
    .rsp_long      (rsp_long),
    .rsp_timeout   (rsp_timeout),
    .rsp_crc_err   (rsp_crc_err),
    .rsp_frame_err (rsp_frame_err)
);

// File: tb/cmd_line_framer_bench.sv
`timescale 1ns/1ps
module cmd_line_framer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_en = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [5:0]   req_index = '0;
    logic [31:0]  req_arg = '0;
    logic [1:0]   req_rsp = '0;
    logic         line_in = 1'b1;
    logic         line_out, line_oe;
    logic         rsp_valid, rsp_long, rsp_timeout, rsp_crc_err, rsp_frame_err;
    logic [135:0] rsp_bits;

    int n_chk = 0;
    int n_bad = 0;
    int gap_bad = 0;

    // Snapshot after the last tick
    logic         s_out, s_oe, s_valid, s_ready;
    logic [135:0] s_bits;
    logic         s_long, s_to, s_crc, s_frm;

    always #2.5 clk = ~clk;

    cmd_line_framer u_cmd_line_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
        .req_rsp(req_rsp), .line_in(line_in), .line_out(line_out),
        .line_oe(line_oe), .rsp_valid(rsp_valid), .rsp_bits(rsp_bits),
        .rsp_long(rsp_long), .rsp_timeout(rsp_timeout),
        .rsp_crc_err(rsp_crc_err), .rsp_frame_err(rsp_frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [135:0] act,
                         input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = c[6] ^ d[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // One bit time: enable pulse, sample, then an idle clock checked for stillness
    task automatic tick(input logic in_bit);
        @(negedge clk);
        line_in = in_bit;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en  = 1'b0;
        s_out = line_out; s_oe = line_oe; s_valid = rsp_valid; s_ready = req_ready;
        s_bits = rsp_bits; s_long = rsp_long; s_to = rsp_timeout;
        s_crc = rsp_crc_err; s_frm = rsp_frame_err;
        @(negedge clk);
        if (line_out !== s_out || line_oe !== s_oe) gap_bad++;
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [1:0] kind, input int delay,
                           input logic [135:0] tok, input int rlen,
                           input bit e_to, input bit e_crc, input bit e_frm,
                           input bit hold_req);
        logic [47:0] exp_tok, got_tok;
        int oe_cnt, early, last_valid;
        check(req_ready === 1'b1, "R4 ready before request", {135'd0, req_ready}, 136'd1);
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_arg = arg; req_rsp = kind;
        @(negedge clk);
        if (hold_req) req_index = ~idx; else req_valid = 1'b0;
        exp_tok = {1'b0, 1'b1, idx, arg, ref_crc({1'b0, 1'b1, idx, arg}), 1'b1};
        oe_cnt = 0; got_tok = '0;
        for (int i = 0; i < 48; i++) begin
            tick(1'b1);
            if (i == 10) req_valid = 1'b0;
            got_tok = {got_tok[46:0], s_out};
            if (s_oe) oe_cnt++;
            if (hold_req && i < 10)
                check(s_ready === 1'b0, "R4 not ready while busy", {135'd0, s_ready}, 136'd0);
        end
        check(got_tok === exp_tok, "R2 token bits", {88'd0, got_tok}, {88'd0, exp_tok});
        check(oe_cnt == 48, "R2 oe bit count", 136'(oe_cnt), 136'd48);
        tick(1'b1);
        check(s_oe === 1'b0 && s_out === 1'b1, "R2 release after token",
              {134'd0, s_oe, s_out}, 136'd1);
        early = 0; last_valid = 0;
        if (kind == 2'b00) begin
            check(s_ready === 1'b1 && s_valid === 1'b0, "R5 no reply",
                  {134'd0, s_ready, s_valid}, 136'd2);
        end else begin
            for (int j = 0; j < delay + rlen; j++) begin
                tick((j < delay) ? 1'b1 : tok[rlen-1-(j-delay)]);
                if (s_valid) begin
                    if (j != delay + rlen - 1) early++; else last_valid = 1;
                end
            end
            check(early == 0 && last_valid == 1, e_to ? "R10 timeout pulse timing" : "R6 valid pulse timing",
                  136'(early), 136'd0);
            if (e_to) begin
                check(s_to === 1'b1 && s_crc === 1'b0 && s_frm === 1'b0 && s_bits === '0,
                      "R10 timeout flags", {s_to, s_crc, s_frm, s_bits[132:0]}, {3'b100, 133'd0});
            end else begin
                check(s_bits === tok, kind[1] ? "R7 long capture" : "R6 short capture", s_bits, tok);
                check(s_long === kind[1] && s_to === 1'b0, kind[1] ? "R7 long flag" : "R6 short flag",
                      {134'd0, s_long, s_to}, {134'd0, kind[1], 1'b0});
                check(s_crc === e_crc, "R8 crc flag", {135'd0, s_crc}, {135'd0, e_crc});
                check(s_frm === e_frm, "R9 frame flag", {135'd0, s_frm}, {135'd0, e_frm});
            end
            check(s_ready === 1'b1, "R4 ready after reply", {135'd0, s_ready}, 136'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_oe === 1'b0 && line_out === 1'b1 && req_ready === 1'b1 && rsp_valid === 1'b0,
              "R1 reset state", {132'd0, line_oe, line_out, req_ready, rsp_valid}, 136'b0110);

        // R3 known CRC values
        check(ref_crc({2'b01, 6'd0, 32'd0}) == 7'h4A, "R3 crc index0", '0, 136'h4A);
        run_cmd(6'd0, 32'd0, 2'b00, 0, '0, 0, 0, 0, 0, 0);
        check(ref_crc({2'b01, 6'd8, 32'h1AA}) == 7'h43, "R3 crc index8", '0, 136'h43);
        run_cmd(6'd8, 32'h1AA, 2'b00, 0, '0, 0, 0, 0, 0, 0);

        // Sweep over all indices and reply kinds
        for (int k = 0; k < 64; k++) begin
            logic [5:0]   ix = 6'(k);
            logic [31:0]  a  = (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0000;
            logic [1:0]   kd = 2'(k % 3);
            logic [135:0] t;
            bit bad_crc = (k % 5 == 0);
            bit bad_end = (k % 7 == 0) || (k % 4 == 2);
            int dl = (k * 7) % 64;
            if (kd == 2'b01) begin
                logic [39:0] h = {2'b00, ix, a ^ 32'h0000FFFF};
                logic [6:0]  c = ref_crc(h) ^ (bad_crc ? 7'h10 : 7'h00);
                t = {88'd0, h, c, ~bad_end};
                run_cmd(ix, a, kd, dl, t, 48, 0, bad_crc, bad_end, 0);
            end else if (kd == 2'b10) begin
                t = {2'b00, 6'h3F, a, a, a, a[31:8], 7'h55, ~bad_end};
                run_cmd(ix, a, (k % 2 == 0) ? 2'b10 : 2'b11, dl, t, 136, 0, 0, bad_end, 0);
            end else begin
                run_cmd(ix, a, kd, 0, '0, 0, 0, 0, 0, 0);
            end
        end

        // R10 boundary: start on the 64th listening pulse, then full timeout
        begin
            logic [39:0] h = {2'b00, 6'd17, 32'hCAFE0001};
            run_cmd(6'd17, 32'h1234, 2'b01, 63, {88'd0, h, ref_crc(h), 1'b1}, 48, 0, 0, 0, 0);
        end
        run_cmd(6'd41, 32'h0, 2'b01, 64, '0, 0, 1, 0, 0, 0);
        run_cmd(6'd2, 32'hFFFFFFFF, 2'b10, 64, '0, 0, 1, 0, 0, 0);

        // R4: request held valid while busy is not taken
        run_cmd(6'd5, 32'h00ABCDEF, 2'b00, 0, '0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            check(s_oe === 1'b0, "R4 no extra command", {135'd0, s_oe}, 136'd0);
        end

        check(gap_bad == 0, "R11 stable without enable", 136'(gap_bad), 136'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule